// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a virtual page number to a physical page number by reading a forward-mapped page table held in memory. A translation request, typically raised after a TLB miss, carries the virtual page number and the access kind: load, store or instruction fetch. The walker reads one table entry per level, starting from a root table pointer. The number of levels is a parameter, and each level indexes its table with its own fixed slice of the virtual page number, most significant slice first. The walk ends with a physical page number, a page fault (some entry on the path is not resident), or a protection fault (the leaf forbids the requested access).

A per-request option selects a bottom-up search. In this mode the walker first reads the leaf entry from a linear window of leaf entries. The window is placed at a base address given with the request and indexed directly by the virtual page number. If that entry is valid, it is used at once. If it is not, the walker falls back to the full root-first walk. After a successful translation, the walker writes the leaf entry back when its reference bit is clear, or when a store finds its dirty bit clear.

The walker handles one request at a time. While it works, `busy` is high and new requests are ignored. Memory is reached through a single port. A read is issued as a one-cycle request and answered later by a valid pulse with data. A write is a one-cycle request with no response.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low. While `busy` is low, `mem_req` stays low.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the `done` cycle and low in the cycle after it. `req_valid` while `busy` is high is ignored: it causes no extra read and no second `done`.
- R3: With `req_bottom_up` low, a walk that meets no invalid entry issues exactly LEVELS reads. The read for level l (level 0 first) goes to word address `table_ppn * 2^IDX_W + slice_l`. Here `table_ppn` is `root_ppn` for level 0 and the previous entry's page number otherwise. `slice_l` is `vpn[VPN_W-1-l*IDX_W -: IDX_W]`.
- R4: A table entry is PPN_W+5 bits wide, laid out as follows. Bits [PPN_W-1:0] hold the page number. Bit PPN_W is valid, bit PPN_W+1 is reference, bit PPN_W+2 is dirty, and bits [PPN_W+4:PPN_W+3] are the permission code. Permission codes: 00 read-only, 01 execute-only, 10 read/write, 11 no access. Access kinds: 00 load, 01 store, 10 fetch, 11 reserved. A load is allowed by 00 or 10, a store only by 10, a fetch only by 01, and the reserved kind by none.
- R5: An entry with valid clear, met during the root-first walk, ends the walk. The walker reports `resp_page_fault` with `resp_ppn` zero, issues no further read and issues no write.
- R6: With `req_bottom_up` high, the first read goes to word address `lin_base + vpn`. If that entry is valid, it is the leaf, and no other read is issued.
- R7: If the bottom-up entry is invalid, a root-first walk as in R3 follows, so a resident page costs 1 + LEVELS reads.
- R8: A valid leaf whose permission does not allow the access kind gives `resp_prot_fault` and never `resp_page_fault`. In this case no write is issued and `resp_ppn` is zero.
- R9: On a permitted access, the leaf is written back once, to the address it was read from, with reference set and, for a store, dirty set. All other bits are unchanged. No write is issued when neither bit changes.
- R10: `done` is a one-cycle pulse. With it, `resp_page_fault` and `resp_prot_fault` are never both high, and on success `resp_ppn` is the leaf page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_kind | input | 2 | Access kind (R4 encoding) |
| req_bottom_up | input | 1 | Try the linear leaf window first |
| root_ppn | input | PPN_W | Page number of the root table |
| lin_base | input | ADDR_W | Word address of the linear leaf window |
| busy | output | 1 | Walk in progress; requests ignored |
| mem_req | output | 1 | Memory access request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | PTE_W | Entry written back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | PTE_W | Entry read |
| done | output | 1 | Walk finished, one-cycle pulse |
| resp_ppn | output | PPN_W | Translated physical page number |
| resp_page_fault | output | 1 | Some entry on the path is not resident |
| resp_prot_fault | output | 1 | Leaf forbids the requested access |

## Verification
The hardest case to reach is a bottom-up miss that then faults partway down the root-first walk. It needs an invalid linear-window entry, a tree that is valid down to a chosen level, and then an invalid entry at that level. The bench builds a fresh table tree for every request, with randomly chosen table pages, fault level, leaf bits and window contents. It predicts the exact read address sequence, so the fallback path and its fault exit are checked address by address. Directed requests pin the leaf write-back corners: reference already set, store onto a clean page, and each access kind against a forbidding permission.

// File: rtl/pw_pkg.sv
package pw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_WRITE,
      ST_RESP
   } walk_st_e;

   localparam logic [1:0] ACC_LOAD  = 2'b00;
   localparam logic [1:0] ACC_STORE = 2'b01;
   localparam logic [1:0] ACC_FETCH = 2'b10;

   localparam logic [1:0] PERM_RO   = 2'b00;
   localparam logic [1:0] PERM_EX   = 2'b01;
   localparam logic [1:0] PERM_RW   = 2'b10;
endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 3,
   localparam int VPN_W = LEVELS * IDX_W,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] level,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] slices [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign slices[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
   end

   always_comb begin
      idx = slices[0];
      for (int i = 1; i < LEVELS; i++) begin
         if (level == LVL_W'(i)) idx = slices[i];
      end
   end
endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
   import pw_pkg::*;
#(
   parameter int PPN_W = 8,
   localparam int PTE_W = PPN_W + 5
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [1:0]       kind,
   output logic             present,
   output logic [PPN_W-1:0] ppn,
   output logic             allowed,
   output logic [PTE_W-1:0] upd,
   output logic             upd_needed
);
   localparam int B_VAL  = PPN_W;
   localparam int B_REF  = PPN_W + 1;
   localparam int B_DRT  = PPN_W + 2;
   localparam int B_PERM = PPN_W + 3;

   logic [1:0] perm;

   assign present = pte[B_VAL];
   assign ppn     = pte[PPN_W-1:0];
   assign perm    = pte[B_PERM +: 2];

   always_comb begin
      unique case (kind)
         ACC_LOAD:  allowed = (perm == PERM_RO) || (perm == PERM_RW);
         ACC_STORE: allowed = (perm == PERM_RW);
         ACC_FETCH: allowed = (perm == PERM_EX);
         default:   allowed = 1'b0;
      endcase
   end

   always_comb begin
      upd        = pte;
      upd[B_REF] = 1'b1;
      if (kind == ACC_STORE) upd[B_DRT] = 1'b1;
      upd_needed = (upd != pte);
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pw_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 3,
   parameter int PPN_W  = 8,
   localparam int VPN_W  = LEVELS * IDX_W,
   localparam int ADDR_W = PPN_W + IDX_W,
   localparam int PTE_W  = PPN_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [1:0]        req_kind,
   input  logic              req_bottom_up,
   input  logic [PPN_W-1:0]  root_ppn,
   input  logic [ADDR_W-1:0] lin_base,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PTE_W-1:0]  mem_wdata,
   input  logic              mem_rvalid,
   input  logic [PTE_W-1:0]  mem_rdata,
   output logic              done,
   output logic [PPN_W-1:0]  resp_ppn,
   output logic              resp_page_fault,
   output logic              resp_prot_fault
);
   localparam int LVL_W = $clog2(LEVELS);
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   if (LEVELS < 2 || LEVELS > 4) begin : g_bad_levels
      $error("pt_walker: LEVELS must lie in 2..4");
   end
   if (IDX_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("pt_walker: IDX_W and PPN_W must be positive");
   end

   walk_st_e          st_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [1:0]        kind_q;
   logic              bu_q;
   logic [ADDR_W-1:0] lin_q;
   logic [PPN_W-1:0]  root_q;
   logic [PPN_W-1:0]  tbl_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [ADDR_W-1:0] wb_addr_q;
   logic [PTE_W-1:0]  wb_data_q;
   logic [PPN_W-1:0]  ppn_q;
   logic              pf_q;
   logic              xf_q;

   logic [IDX_W-1:0]  lvl_idx;
   logic [ADDR_W-1:0] walk_addr;
   logic              ent_present;
   logic [PPN_W-1:0]  ent_ppn;
   logic              ent_allowed;
   logic [PTE_W-1:0]  ent_upd;
   logic              ent_upd_needed;

   pw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_idx (
      .vpn   (vpn_q),
      .level (lvl_q),
      .idx   (lvl_idx)
   );

   pw_pte_eval #(.PPN_W(PPN_W)) u_eval (
      .pte        (mem_rdata),
      .kind       (kind_q),
      .present    (ent_present),
      .ppn        (ent_ppn),
      .allowed    (ent_allowed),
      .upd        (ent_upd),
      .upd_needed (ent_upd_needed)
   );

   assign walk_addr = bu_q ? (lin_q + ADDR_W'(vpn_q)) : {tbl_q, lvl_idx};

   assign busy      = (st_q != ST_IDLE);
   assign mem_req   = (st_q == ST_ISSUE) || (st_q == ST_WRITE);
   assign mem_we    = (st_q == ST_WRITE);
   assign mem_addr  = (st_q == ST_WRITE) ? wb_addr_q : walk_addr;
   assign mem_wdata = wb_data_q;
   assign done      = (st_q == ST_RESP);
   assign resp_ppn        = ppn_q;
   assign resp_page_fault = pf_q;
   assign resp_prot_fault = xf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         vpn_q     <= '0;
         kind_q    <= '0;
         bu_q      <= 1'b0;
         lin_q     <= '0;
         root_q    <= '0;
         tbl_q     <= '0;
         lvl_q     <= '0;
         wb_addr_q <= '0;
         wb_data_q <= '0;
         ppn_q     <= '0;
         pf_q      <= 1'b0;
         xf_q      <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vpn_q  <= req_vpn;
                  kind_q <= req_kind;
                  bu_q   <= req_bottom_up;
                  lin_q  <= lin_base;
                  root_q <= root_ppn;
                  tbl_q  <= root_ppn;
                  lvl_q  <= '0;
                  ppn_q  <= '0;
                  pf_q   <= 1'b0;
                  xf_q   <= 1'b0;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rvalid) begin
                  if (bu_q && !ent_present) begin
                     bu_q  <= 1'b0;
                     tbl_q <= root_q;
                     lvl_q <= '0;
                     st_q  <= ST_ISSUE;
                  end else if (!ent_present) begin
                     pf_q <= 1'b1;
                     st_q <= ST_RESP;
                  end else if (!bu_q && lvl_q != LAST_LVL) begin
                     tbl_q <= ent_ppn;
                     lvl_q <= lvl_q + LVL_W'(1);
                     st_q  <= ST_ISSUE;
                  end else if (!ent_allowed) begin
                     xf_q <= 1'b1;
                     st_q <= ST_RESP;
                  end else begin
                     ppn_q <= ent_ppn;
                     if (ent_upd_needed) begin
                        wb_addr_q <= walk_addr;
                        wb_data_q <= ent_upd;
                        st_q      <= ST_WRITE;
                     end else begin
                        st_q <= ST_RESP;
                     end
                  end
               end
            end
            ST_WRITE: st_q <= ST_RESP;
            ST_RESP:  st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 3,
   parameter int PPN_W  = 8,
   localparam int ADDR_W = PPN_W + IDX_W,
   localparam int PTE_W  = PPN_W + 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [PTE_W-1:0]  mem_wdata,
   input logic              done,
   input logic              resp_page_fault,
   input logic              resp_prot_fault
);
   logic [3:0] rd_walk;
   logic [3:0] wr_walk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_walk <= '0;
         wr_walk <= '0;
      end else if (req_valid && !busy) begin
         rd_walk <= '0;
         wr_walk <= '0;
      end else begin
         if (mem_req && !mem_we) rd_walk <= rd_walk + 4'd1;
         if (mem_req && mem_we)  wr_walk <= wr_walk + 4'd1;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(resp_page_fault && resp_prot_fault));
   // R9
   wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[PPN_W] && mem_wdata[PPN_W+1]));
   // R7
   read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_walk <= 4'(LEVELS + 1)));
   // R8
   fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (resp_page_fault || resp_prot_fault)) |-> (wr_walk == 4'd0));
   // R9
   single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_walk <= 4'd1));

   logic unused_addr;
   assign unused_addr = ^mem_addr;
endmodule

bind pt_walker pt_walker_chk #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .busy            (busy),
   .mem_req         (mem_req),
   .mem_we          (mem_we),
   .mem_addr        (mem_addr),
   .mem_wdata       (mem_wdata),
   .done            (done),
   .resp_page_fault (resp_page_fault),
   .resp_prot_fault (resp_prot_fault)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
   localparam int LEVELS = 3;
   localparam int IDX_W  = 3;
   localparam int PPN_W  = 8;
   localparam int VPN_W  = LEVELS * IDX_W;
   localparam int ADDR_W = PPN_W + IDX_W;
   localparam int PTE_W  = PPN_W + 5;
   localparam int MEM_N  = 1 << ADDR_W;
   localparam int LIN_BASE = 1536;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              req_valid;
   logic [VPN_W-1:0]  req_vpn;
   logic [1:0]        req_kind;
   logic              req_bottom_up;
   logic [PPN_W-1:0]  root_ppn;
   logic [ADDR_W-1:0] lin_base;
   logic              busy, mem_req, mem_we, done;
   logic [ADDR_W-1:0] mem_addr;
   logic [PTE_W-1:0]  mem_wdata;
   logic              mem_rvalid;
   logic [PTE_W-1:0]  mem_rdata;
   logic [PPN_W-1:0]  resp_ppn;
   logic              resp_page_fault, resp_prot_fault;

   pt_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
      .req_kind(req_kind), .req_bottom_up(req_bottom_up), .root_ppn(root_ppn),
      .lin_base(lin_base), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done(done), .resp_ppn(resp_ppn),
      .resp_page_fault(resp_page_fault), .resp_prot_fault(resp_prot_fault)
   );

   logic [PTE_W-1:0]  mem [MEM_N];
   int                rd_cnt = 0;
   int                wr_cnt = 0;
   logic [ADDR_W-1:0] rd_log [16];
   logic [ADDR_W-1:0] wr_addr_seen;
   logic [PTE_W-1:0]  wr_data_seen;

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         if (mem_we) begin
            wr_addr_seen = mem_addr;
            wr_data_seen = mem_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr];
            rd_log[rd_cnt % 16] = mem_addr;
            rd_cnt = rd_cnt + 1;
         end
      end
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [PTE_W-1:0] mk(input logic [PPN_W-1:0] p, input bit v,
                                            input bit r, input bit d, input logic [1:0] pm);
      return {pm, d, r, v, p};
   endfunction

   function automatic bit perm_ok(input logic [1:0] pm, input logic [1:0] k);
      case (k)
         2'b00:   return (pm == 2'b00) || (pm == 2'b10);
         2'b01:   return pm == 2'b10;
         2'b10:   return pm == 2'b01;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int slice_of(input int vpn, input int l);
      return (vpn >> ((LEVELS - 1 - l) * IDX_W)) & ((1 << IDX_W) - 1);
   endfunction

   // fault_lvl >= LEVELS means no invalid entry in the tree
   task automatic run(input int vpn, input logic [1:0] kind, input bit bu, input bit bu_hit,
                      input int fault_lvl, input logic [PPN_W-1:0] lppn, input bit r,
                      input bit d, input logic [1:0] pm, input bit junk);
      int tbl [LEVELS];
      int exp_rd [8];
      int n_exp = 0;
      logic [PTE_W-1:0] leaf;
      int leaf_addr;
      bit exp_pf = 0, exp_xf = 0, exp_wr = 0;
      logic [PTE_W-1:0] exp_wdata = '0;
      logic [PPN_W-1:0] exp_ppn = '0;
      int rd0, wr0, wait_n;
      bit got_pf, got_xf;
      logic [PPN_W-1:0] got_ppn;
      string tag_out, tag_rd;

      for (int i = 0; i < MEM_N; i++) mem[i] = '0;
      for (int l = 0; l < LEVELS; l++) begin
         bit dup;
         do begin
            tbl[l] = $urandom_range(1, 191);
            dup = 0;
            for (int m = 0; m < l; m++) if (tbl[m] == tbl[l]) dup = 1;
         end while (dup);
      end
      for (int l = 0; l < LEVELS - 1; l++)
         mem[tbl[l] * (1 << IDX_W) + slice_of(vpn, l)] =
            (fault_lvl == l) ? mk(PPN_W'($urandom), 0, 1, 1, 2'b10)
                             : mk(PPN_W'(tbl[l+1]), 1, 0, 0, 2'b00);
      leaf_addr = tbl[LEVELS-1] * (1 << IDX_W) + slice_of(vpn, LEVELS - 1);
      mem[leaf_addr] = mk(lppn, fault_lvl != LEVELS - 1, r, d, pm);
      mem[LIN_BASE + vpn] = bu_hit ? mk(lppn ^ 8'h5a, 1, r, d, pm)
                                   : mk(PPN_W'($urandom), 0, 1, 0, 2'b10);

      // expected read sequence and outcome
      if (bu) begin
         exp_rd[n_exp++] = LIN_BASE + vpn;
      end
      if (bu && bu_hit) begin
         leaf = mem[LIN_BASE + vpn];
         leaf_addr = LIN_BASE + vpn;
      end else begin
         leaf = mem[leaf_addr];
         for (int l = 0; l < LEVELS; l++) begin
            exp_rd[n_exp++] = tbl[l] * (1 << IDX_W) + slice_of(vpn, l);
            if (fault_lvl == l) begin
               exp_pf = 1;
               break;
            end
         end
      end
      if (!exp_pf) begin
         if (!perm_ok(leaf[PPN_W+3 +: 2], kind)) exp_xf = 1;
         else begin
            exp_ppn = leaf[PPN_W-1:0];
            exp_wdata = leaf;
            exp_wdata[PPN_W+1] = 1'b1;
            if (kind == 2'b01) exp_wdata[PPN_W+2] = 1'b1;
            exp_wr = (exp_wdata != leaf);
         end
      end
      tag_out = exp_pf ? "R5" : exp_xf ? "R8" : bu ? (bu_hit ? "R6" : "R7") : "R3";
      tag_rd  = bu ? (bu_hit ? "R6" : "R7") : (exp_pf ? "R5" : "R3");

      rd0 = rd_cnt;
      wr0 = wr_cnt;
      @(negedge clk);
      req_valid = 1'b1;
      req_vpn = VPN_W'(vpn);
      req_kind = kind;
      req_bottom_up = bu;
      root_ppn = PPN_W'(tbl[0]);
      lin_base = ADDR_W'(LIN_BASE);
      @(negedge clk);
      chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
      if (junk) begin
         req_vpn = VPN_W'($urandom);
         req_bottom_up = ~bu;
      end else begin
         req_valid = 1'b0;
      end
      wait_n = 0;
      while (!done && wait_n < 100) begin
         @(negedge clk);
         wait_n++;
      end
      req_valid = 1'b0;
      chk(done == 1'b1, "R10", "done seen", done, 1);
      got_pf = resp_page_fault;
      got_xf = resp_prot_fault;
      got_ppn = resp_ppn;
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", done, 0);
      chk(busy == 1'b0, "R2", "busy after done", busy, 0);
      chk(got_pf == exp_pf, tag_out, "page fault", got_pf, exp_pf);
      chk(got_xf == exp_xf, tag_out, "prot fault", got_xf, exp_xf);
      chk(got_ppn == exp_ppn, tag_out, "ppn", got_ppn, exp_ppn);
      chk(rd_cnt - rd0 == n_exp, junk ? "R2" : tag_rd, "read count", rd_cnt - rd0, n_exp);
      if (rd_cnt - rd0 == n_exp)
         for (int i = 0; i < n_exp; i++)
            chk(int'(rd_log[(rd0 + i) % 16]) == exp_rd[i], tag_rd, "read addr",
                rd_log[(rd0 + i) % 16], exp_rd[i]);
      chk(wr_cnt - wr0 == int'(exp_wr), exp_pf ? "R5" : exp_xf ? "R8" : "R9",
          "write count", wr_cnt - wr0, exp_wr);
      if (exp_wr && wr_cnt - wr0 == 1) begin
         chk(int'(wr_addr_seen) == leaf_addr, "R9", "write addr", wr_addr_seen, leaf_addr);
         chk(wr_data_seen == exp_wdata, "R9", "write data", wr_data_seen, exp_wdata);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_vpn = '0;
      req_kind = '0;
      req_bottom_up = 1'b0;
      root_ppn = '0;
      lin_base = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1", "busy in reset", busy, 0);
      chk(done == 0, "R1", "done in reset", done, 0);
      chk(mem_req == 0, "R1", "mem_req in reset", mem_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 0 && mem_req == 0, "R1", "idle after reset", {busy, mem_req}, 0);

      // directed corners
      run(9'h1a5, 2'b00, 0, 0, LEVELS, 8'h33, 0, 0, 2'b00, 0); // R3 load, ref clear -> R9 write
      run(9'h0f0, 2'b01, 0, 0, LEVELS, 8'h44, 1, 0, 2'b10, 0); // R9 store sets dirty
      run(9'h0f1, 2'b00, 0, 0, LEVELS, 8'h45, 1, 0, 2'b10, 0); // R9 no write needed
      run(9'h111, 2'b00, 0, 0, 0, 8'h10, 0, 0, 2'b00, 0);      // R5 root fault
      run(9'h111, 2'b00, 0, 0, LEVELS-1, 8'h10, 0, 0, 2'b00, 0); // R5 leaf fault
      run(9'h077, 2'b10, 1, 1, LEVELS, 8'h21, 0, 0, 2'b01, 0); // R6 hit
      run(9'h078, 2'b01, 1, 0, LEVELS, 8'h22, 1, 1, 2'b10, 0); // R7 miss
      run(9'h079, 2'b00, 1, 0, 1, 8'h23, 0, 0, 2'b00, 0);      // R7 miss then R5
      run(9'h100, 2'b01, 0, 0, LEVELS, 8'h24, 0, 0, 2'b00, 0); // R8 store on read-only
      run(9'h101, 2'b10, 0, 0, LEVELS, 8'h25, 0, 0, 2'b10, 0); // R8 fetch on rw
      run(9'h102, 2'b00, 0, 0, LEVELS, 8'h26, 0, 0, 2'b01, 0); // R8 load on exec
      run(9'h103, 2'b11, 0, 0, LEVELS, 8'h27, 0, 0, 2'b10, 0); // R4 reserved kind
      run(9'h104, 2'b00, 0, 0, LEVELS, 8'h28, 0, 0, 2'b11, 0); // R4 no-access code
      run(9'h155, 2'b00, 0, 0, LEVELS, 8'h29, 0, 0, 2'b10, 1); // R2 requests while busy

      // constrained random
      for (int n = 0; n < 250; n++) begin
         int fl;
         fl = $urandom_range(0, LEVELS + 3);
         run($urandom_range(0, (1 << VPN_W) - 1), 2'($urandom_range(0, 3)),
             1'($urandom), 1'($urandom), fl, PPN_W'($urandom),
             1'($urandom), 1'($urandom), 2'($urandom), ($urandom_range(0, 7) == 0));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule